// File: doc/BRIEF.md
# Page write controller

This block converts byte writes made on an asynchronous static-RAM-style bus into page-sized commits to a memory array. The bus inputs are chip enable, output enable and write enable, all active low, plus a 19-bit address and an 8-bit data bus. All of them are taken as already synchronised to the system clock. The first accepted write opens a load period and fixes the page, which is the upper eleven address bits. Every further byte aimed at that page goes into a 256-entry page register, and a per-offset mask records which offsets were loaded.

The load period ends when a configurable number of clock cycles passes with no accepted byte. The block then raises `busy` for a fixed programming interval. During the first 256 cycles of that interval it walks the offsets in ascending order and drives one array write per clock for each loaded offset only. At the end of the interval the mask is cleared and `busy` falls. Writes seen while `busy` is high are dropped.

Both the load window and the programming interval are parameters counted in clock cycles. A simulation can therefore use short values, while silicon uses the real 150 µs and 10 ms figures.

Top module: `page_write_ctrl`

## Requirements
- R1: A write is recognised only while `bus_ce_n`=0, `bus_we_n`=0 and `bus_oe_n`=1 all hold in the same cycle, and the byte takes effect in the cycle this condition ends. An attempt made with `bus_oe_n` low or `bus_ce_n` high loads nothing and starts no programming.
- R2: The address is taken in the first cycle of the write condition, which is the later of the two strobe falls. The data is taken in the last cycle of the write condition. Address changes made later in the same strobe are not used.
- R3: The first byte of a load period fixes the page (address bits 18..8). A later byte whose address bits 18..8 differ is ignored, and the page does not change until programming ends.
- R4: Every accepted byte restarts the load window. When LOAD_WIN_CYC clock cycles pass after the last accepted byte with no further accepted byte, `busy` rises.
- R5: Bytes may be loaded in any order. An offset written more than once in a load period commits the value written last.
- R6: While busy, `arr_we` pulses once for each loaded offset and for no other offset. Commits go in ascending offset order, one per clock. `arr_addr` is {page, offset} and `arr_wdata` is the loaded byte.
- R7: `busy` stays high for exactly PROG_CYC cycles. A write made during that time is ignored and does not open a new load period.
- R8: When programming ends the loaded-offset mask is empty, so the next page commits only the bytes of its own load period.
- R9: After reset `busy` and `arr_we` are low and no offset is marked as loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_oe_n | input | 1 | Output enable, active low (write inhibit when low) |
| bus_we_n | input | 1 | Write enable, active low |
| bus_addr | input | 19 | Byte address: bits 18..8 page, bits 7..0 offset |
| bus_wdata | input | 8 | Write data |
| busy | output | 1 | High during the programming interval |
| arr_we | output | 1 | Array write strobe, one byte per clock |
| arr_addr | output | 19 | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The assertions assume the strobe, address and data inputs are already synchronous to `clk` and that PROG_CYC is at least the page size, so the commit walk always fits inside the programming interval. The stimulus changes the inputs only on falling clock edges and keeps each strobe low for at least two cycles. It holds the page bits steady during a strobe, except for the one test that moves the address mid-strobe to show that it is ignored. The ignored writes, the window restart and the page mismatch are all observed at `busy` and on the array write port.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
    localparam int ADDR_W     = 19;
    localparam int DATA_W     = 8;
    localparam int OFS_W      = 8;
    localparam int PAGE_W     = ADDR_W - OFS_W;
    localparam int PAGE_BYTES = 1 << OFS_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [OFS_W-1:0]  ofs;
        logic [DATA_W-1:0] data;
    } byte_ev_t;

    function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:OFS_W];
    endfunction
endpackage

// File: rtl/pwc_bus_decode.sv
module pwc_bus_decode
    import pwc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ev_valid,
    output byte_ev_t          ev
);
    logic              strobe;
    logic              strobe_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    assign strobe = !ce_n && !we_n && oe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            addr_q   <= '0;
            data_q   <= '0;
        end else begin
            strobe_q <= strobe;
            if (strobe && !strobe_q) addr_q <= addr;
            if (strobe)              data_q <= wdata;
        end
    end

    // byte completes in the cycle the write condition ends
    assign ev_valid = strobe_q && !strobe;

    always_comb begin
        ev.page = page_of(addr_q);
        ev.ofs  = addr_q[OFS_W-1:0];
        ev.data = data_q;
    end
endmodule

// File: rtl/pwc_page_buf.sv
module pwc_page_buf
    import pwc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [OFS_W-1:0]      wr_ofs,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  clr,
    input  logic [OFS_W-1:0]      rd_ofs,
    output logic [DATA_W-1:0]     rd_data,
    output logic [PAGE_BYTES-1:0] mask
);
    logic [DATA_W-1:0] mem [PAGE_BYTES];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ofs] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            mask <= '0;
        end else if (wr_en) begin
            mask[wr_ofs] <= 1'b1;
        end
    end

    assign rd_data = mem[rd_ofs];
endmodule

// File: rtl/pwc_sequencer.sv
module pwc_sequencer
    import pwc_pkg::*;
#(
    parameter int LOAD_WIN_CYC = 7500,
    parameter int PROG_CYC     = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  byte_ev_t          ev,
    output logic [PAGE_W-1:0] page_q,
    output logic              buf_wr,
    output logic              buf_clr,
    output logic              scan_act,
    output logic [OFS_W-1:0]  scan_ofs,
    output logic              busy
);
    localparam int WIN_W = $clog2(LOAD_WIN_CYC + 1);
    localparam int PRG_W = $clog2(PROG_CYC + 1);

    if (PROG_CYC < PAGE_BYTES) begin : g_bad_prog
        $error("PROG_CYC must cover one full page walk");
    end

    seq_state_t       state;
    logic [WIN_W-1:0] win_cnt;
    logic [PRG_W-1:0] prg_cnt;
    logic             page_hit;
    logic             win_done;
    logic             prg_done;

    assign page_hit = (ev.page == page_q);
    assign buf_wr   = ev_valid && ((state == ST_IDLE) || ((state == ST_LOAD) && page_hit));
    assign win_done = (win_cnt == WIN_W'(LOAD_WIN_CYC - 1));
    assign prg_done = (prg_cnt == PRG_W'(PROG_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            win_cnt <= '0;
            prg_cnt <= '0;
            page_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (ev_valid) begin
                        page_q  <= ev.page;
                        win_cnt <= '0;
                        state   <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (buf_wr) begin
                        win_cnt <= '0;
                    end else if (win_done) begin
                        prg_cnt <= '0;
                        state   <= ST_PROG;
                    end else begin
                        win_cnt <= win_cnt + 1'b1;
                    end
                end
                ST_PROG: begin
                    if (prg_done) state <= ST_IDLE;
                    else          prg_cnt <= prg_cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state == ST_PROG);
    assign scan_act = busy && (32'(prg_cnt) < PAGE_BYTES);
    assign scan_ofs = prg_cnt[OFS_W-1:0];
    assign buf_clr  = busy && prg_done;
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl
    import pwc_pkg::*;
#(
    parameter int LOAD_WIN_CYC = 7500,
    parameter int PROG_CYC     = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_ce_n,
    input  logic              bus_oe_n,
    input  logic              bus_we_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);
    logic                  ev_valid;
    byte_ev_t              ev;
    logic [PAGE_W-1:0]     page_q;
    logic                  buf_wr;
    logic                  buf_clr;
    logic                  scan_act;
    logic [OFS_W-1:0]      scan_ofs;
    logic [PAGE_BYTES-1:0] mask;
    logic [DATA_W-1:0]     rd_data;

    pwc_bus_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (bus_ce_n),
        .oe_n     (bus_oe_n),
        .we_n     (bus_we_n),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .ev_valid (ev_valid),
        .ev       (ev)
    );

    pwc_sequencer #(
        .LOAD_WIN_CYC (LOAD_WIN_CYC),
        .PROG_CYC     (PROG_CYC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .ev_valid (ev_valid),
        .ev       (ev),
        .page_q   (page_q),
        .buf_wr   (buf_wr),
        .buf_clr  (buf_clr),
        .scan_act (scan_act),
        .scan_ofs (scan_ofs),
        .busy     (busy)
    );

    pwc_page_buf u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (buf_wr),
        .wr_ofs  (ev.ofs),
        .wr_data (ev.data),
        .clr     (buf_clr),
        .rd_ofs  (scan_ofs),
        .rd_data (rd_data),
        .mask    (mask)
    );

    assign arr_we    = scan_act && mask[scan_ofs];
    assign arr_addr  = {page_q, scan_ofs};
    assign arr_wdata = rd_data;
endmodule

// File: rtl/page_write_ctrl_chk.sv
module page_write_ctrl_chk
    import pwc_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  busy,
    input logic                  arr_we,
    input logic [ADDR_W-1:0]     arr_addr,
    input logic                  buf_wr,
    input logic [PAGE_W-1:0]     page_q,
    input logic [PAGE_BYTES-1:0] mask
);
    assert_commit_in_prog_R6: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy);

    assert_no_repeat_R6: assert property (@(posedge clk) disable iff (rst)
        (arr_we && $past(arr_we)) |-> (arr_addr != $past(arr_addr)));

    assert_no_load_busy_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> !buf_wr);

    assert_page_hold_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> $stable(page_q));

    assert_mask_clear_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (mask == '0));

    assert_reset_state_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !arr_we && (mask == '0)));
endmodule

bind page_write_ctrl page_write_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .arr_we   (arr_we),
    .arr_addr (arr_addr),
    .buf_wr   (buf_wr),
    .page_q   (page_q),
    .mask     (mask)
);

// File: tb/page_write_ctrl_bench.sv
module page_write_ctrl_bench;
    localparam int LW = 16;
    localparam int PC = 300;
    localparam int NV = 8;
    // {page[10:0], offset[7:0], data[7:0], last_of_burst}
    localparam logic [27:0] VEC [0:NV-1] = '{
        {11'h012, 8'h05, 8'h11, 1'b0},
        {11'h012, 8'h02, 8'h22, 1'b0},
        {11'h012, 8'h05, 8'h33, 1'b0},
        {11'h012, 8'hFF, 8'h44, 1'b1},
        {11'h7FF, 8'h00, 8'hA5, 1'b1},
        {11'h400, 8'h80, 8'hAA, 1'b0},
        {11'h400, 8'h10, 8'hBB, 1'b0},
        {11'h400, 8'h81, 8'hCC, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_ce_n = 1'b1;
    logic        bus_oe_n = 1'b1;
    logic        bus_we_n = 1'b1;
    logic [18:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        busy;
    logic        arr_we;
    logic [18:0] arr_addr;
    logic [7:0]  arr_wdata;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    int log_n = 0;
    bit busy_seen = 1'b0;
    logic [18:0] log_a [0:1023];
    logic [7:0]  log_d [0:1023];

    // bench-side model of one load period
    logic [7:0]  md [0:255];
    bit          mm [0:255];
    logic [10:0] mpage;
    bit          mopen;
    int          mbase;

    always #10 clk = ~clk;

    page_write_ctrl #(.LOAD_WIN_CYC(LW), .PROG_CYC(PC)) u_page_write_ctrl (
        .clk(clk), .rst(rst), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
        .bus_we_n(bus_we_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (busy) busy_seen <= 1'b1;
        if (arr_we) begin
            log_a[log_n % 1024] <= arr_addr;
            log_d[log_n % 1024] <= arr_wdata;
            log_n <= log_n + 1;
        end
        if (cyc == 100000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog R7: actual=%0d expected<%0d cycles", cyc, 100000);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write(input logic [18:0] a, input logic [7:0] d, input bit oe_low, input bit ce_high);
        @(negedge clk);
        bus_addr = a; bus_wdata = d;
        bus_ce_n = ce_high; bus_oe_n = !oe_low; bus_we_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bus_we_n = 1'b1;
        @(negedge clk);
        bus_ce_n = 1'b1; bus_oe_n = 1'b1;
    endtask

    // address and data move one cycle into the strobe
    task automatic bus_write_shift(input logic [18:0] a1, input logic [7:0] d1,
                                   input logic [18:0] a2, input logic [7:0] d2);
        @(negedge clk);
        bus_addr = a1; bus_wdata = d1;
        bus_ce_n = 1'b0; bus_oe_n = 1'b1; bus_we_n = 1'b0;
        @(negedge clk);
        bus_addr = a2; bus_wdata = d2;
        @(negedge clk);
        bus_we_n = 1'b1;
        @(negedge clk);
        bus_ce_n = 1'b1;
    endtask

    task automatic model_clear();
        for (int i = 0; i < 256; i++) mm[i] = 1'b0;
        mopen = 1'b0;
        mbase = log_n;
    endtask

    task automatic model_put(input logic [10:0] pg, input logic [7:0] o, input logic [7:0] d);
        if (!mopen) begin
            mopen = 1'b1;
            mpage = pg;
        end
        if (pg == mpage) begin
            md[o] = d;
            mm[o] = 1'b1;
        end
    endtask

    task automatic finish_burst(input bit check_len);
        int guard = 0;
        int blen = 0;
        int idx = 0;
        while (!busy && guard < LW + 8) begin
            @(negedge clk);
            guard++;
        end
        chk(busy, "R4", "busy rises after window", busy, 1);
        while (busy && blen < PC + 20) begin
            @(negedge clk);
            blen++;
        end
        if (check_len) chk(blen == PC, "R7", "busy length", blen, PC);
        for (int o = 0; o < 256; o++) begin
            if (mm[o]) begin
                chk(log_a[(mbase + idx) % 1024] == {mpage, 8'(o)}, "R6", "commit address",
                    log_a[(mbase + idx) % 1024], {mpage, 8'(o)});
                chk(log_d[(mbase + idx) % 1024] == md[o], "R5", "commit data",
                    log_d[(mbase + idx) % 1024], md[o]);
                idx++;
            end
        end
        chk(log_n - mbase == idx, "R8", "commit count", log_n - mbase, idx);
    endtask

    initial begin
        // reset state (R9)
        idle(4);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy, "R9", "busy after reset", busy, 0);
        chk(!arr_we, "R9", "arr_we after reset", arr_we, 0);

        // inhibited attempts (R1)
        bus_write({11'h001, 8'h01}, 8'h5A, 1'b1, 1'b0);
        bus_write({11'h001, 8'h02}, 8'h5B, 1'b0, 1'b1);
        idle(3 * LW);
        chk(!busy_seen, "R1", "inhibited write started programming", busy_seen, 0);
        chk(log_n == 0, "R1", "inhibited write committed", log_n, 0);

        // table of page loads
        model_clear();
        for (int v = 0; v < NV; v++) begin
            bus_write({VEC[v][27:17], VEC[v][16:9]}, VEC[v][8:1], 1'b0, 1'b0);
            model_put(VEC[v][27:17], VEC[v][16:9], VEC[v][8:1]);
            if (VEC[v][0]) begin
                finish_burst(1'b1);
                model_clear();
            end
        end

        // R2 address from strobe start, data from strobe end; R3 foreign page ignored
        model_clear();
        bus_write_shift({11'h055, 8'h01}, 8'h10, {11'h056, 8'h77}, 8'h5A);
        model_put(11'h055, 8'h01, 8'h5A);
        bus_write({11'h056, 8'h02}, 8'h20, 1'b0, 1'b0);
        model_put(11'h056, 8'h02, 8'h20);
        finish_burst(1'b1);
        chk(log_a[mbase % 1024] == {11'h055, 8'h01}, "R2", "address from strobe start",
            log_a[mbase % 1024], {11'h055, 8'h01});

        // R4 window restart and exact expiry, R7 write during busy ignored
        model_clear();
        bus_write({11'h123, 8'h10}, 8'h01, 1'b0, 1'b0);
        model_put(11'h123, 8'h10, 8'h01);
        idle(6);
        chk(!busy, "R4", "busy early", busy, 0);
        bus_write({11'h123, 8'h11}, 8'h02, 1'b0, 1'b0);
        model_put(11'h123, 8'h11, 8'h02);
        idle(10);
        chk(!busy, "R4", "window restarted", busy, 0);
        idle(5);
        chk(!busy, "R4", "one cycle before expiry", busy, 0);
        idle(1);
        chk(busy, "R4", "expiry", busy, 1);
        bus_write({11'h123, 8'h30}, 8'h99, 1'b0, 1'b0);
        finish_burst(1'b0);
        idle(2 * LW);
        chk(!busy, "R7", "write during busy opened a load", busy, 0);

        summary();
        $finish;
    end
endmodule